// File: doc/BRIEF.md
# Memory-Mapped Network Byte Mailbox

This block sits between a processor bus and a plain byte-wide network interface. It carries whole frames in both directions. Software finds the block by reading a fixed eight-character identifier. It learns that a frame has arrived from a latched interrupt flag and a byte count, then pulls the frame out one byte per read of a receive window. Each read lowers the count by one.

To send, software programs a frame length and then writes that many bytes into a transmit window. The block takes the frame into its own buffer, clears the length and replays the bytes on the outgoing stream. When the last byte has been handed over, it raises a transmit-done flag. An interrupt control word holds the two event flags and a test bit, and the interrupt line is their OR. A frame waiting in the receive buffer blocks the next one until software has both drained it and acknowledged it.

Top module: `netmbox`

## Requirements
- R1: Aligned word reads at byte offset 0x00 and 0x04 return the identifier "MBOXNET1", with the first character in bits 7:0 and each later character 8 bits higher, so 0x00 reads 0x584F424D and 0x04 reads 0x3154454E. Offset 0x18, any offset from 0x24 up, and any offset with bits 1:0 nonzero read 0. Writes to those offsets have no effect.
- R2: After reset, busy (0x08), receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0, irq is low, rx_ready is high and tx_valid is low.
- R3: When a byte marked rx_last is accepted, the receive count becomes the frame length in bytes, and bit 1 of interrupt control becomes set.
- R4: A read of the receive window (0x1C) returns the next stored frame byte in bits 7:0, with bits 31:8 at zero, and lowers the receive count by one. With the count at 0, a read returns 0 and the count stays at 0.
- R5: rx_ready is low, and offered bytes are not taken, while bit 1 of interrupt control is set or the receive count is nonzero.
- R6: Bytes of a frame beyond FRAME_MAX (64 by default) are discarded, and the count of such a frame is FRAME_MAX.
- R7: After a length N is written to 0x10, the transmit count reads N. After the Nth write to the transmit window (0x20), it reads 0. The N low bytes then appear on tx_data in write order, one per tx_valid/tx_ready handshake, with tx_last on the Nth byte only. Bit 0 of interrupt control becomes set on the final handshake.
- R8: A transmit length above FRAME_MAX reads back as FRAME_MAX. Window writes made while the transmit count is 0 are dropped. A length write made while a frame is still on the stream is ignored.
- R9: Busy (0x08, bit 0) reads 1 between the first and the last byte of a received frame, and while a transmit frame has not finished on the stream.
- R10: Writing 1 to bit 0 or bit 1 of interrupt control clears that bit. Writing 0 to it leaves it unchanged.
- R11: Interrupt control bit 31 is set by a write with bit 31 at 1 and cleared by a write with bit 31 at 0. It also clears on the cycle after any read of 0x14, and that read still returns it as 1.
- R12: irq is high exactly when any of bits 0, 1 or 31 of interrupt control is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the 0x40 region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte this cycle |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink takes the outgoing byte this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench reads the receive window past the end of a frame. A design that did not stop at zero would wrap the count or return stale buffer bytes. It offers a new frame while the old one is unacknowledged, and again after draining but before acknowledging. A design that gated on only one condition would overwrite the stored frame. It sends a frame longer than the buffer, and also over-writes the transmit window and changes the length mid-send, so that missing clamps or missing drops show up as wrong counts or extra stream bytes. Finally it reads the test bit twice and writes 1 to it twice, to catch a test bit that fails to clear on read or that clears on a write of 1.

// File: rtl/netmbox_pkg.sv
// Package: shared word indices and helpers for the network mailbox.
// Assumes bus offsets are byte addresses with the word index in bits 5:2.
package netmbox_pkg;

    localparam logic [3:0] W_ID_LO  = 4'd0;  // 0x00
    localparam logic [3:0] W_ID_HI  = 4'd1;  // 0x04
    localparam logic [3:0] W_BUSY   = 4'd2;  // 0x08
    localparam logic [3:0] W_RXCNT  = 4'd3;  // 0x0C
    localparam logic [3:0] W_TXCNT  = 4'd4;  // 0x10
    localparam logic [3:0] W_INTCTL = 4'd5;  // 0x14
    localparam logic [3:0] W_INFO   = 4'd6;  // 0x18
    localparam logic [3:0] W_RXWIN  = 4'd7;  // 0x1C
    localparam logic [3:0] W_TXWIN  = 4'd8;  // 0x20

    // Reorders a string literal (first character at the top) so that the
    // first character lands in bits 7:0.
    function automatic logic [63:0] pack_id(input logic [63:0] txt);
        logic [63:0] res;
        for (int i = 0; i < 8; i++) begin
            res[8*i +: 8] = txt[8*(7-i) +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/netmbox_rx.sv
// Receive side: stores one incoming frame and hands it out byte by byte.
// Assumes rd_pop and a stream byte never coincide (the stream is only taken
// while the count is zero). Bytes beyond FRAME_MAX are discarded.
module netmbox_rx #(
    parameter int FRAME_MAX = 64,
    localparam int CW = $clog2(FRAME_MAX + 1),
    localparam int AW = $clog2(FRAME_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          hold,
    input  logic          rd_pop,
    output logic          rx_ready,
    output logic [CW-1:0] rx_cnt,
    output logic [7:0]    rx_byte,
    output logic          rx_active,
    output logic          frame_done
);
    localparam logic [CW-1:0] MAXC = CW'(FRAME_MAX);

    logic [7:0]    mem [FRAME_MAX];
    logic [CW-1:0] wr_cnt;
    logic [AW-1:0] rd_ptr;
    logic          take;
    logic          room;

    assign rx_ready   = !hold && (rx_cnt == '0);
    assign take       = rx_valid && rx_ready;
    assign room       = (wr_cnt < MAXC);
    assign frame_done = take && rx_last;
    assign rx_byte    = (rx_cnt != '0) ? mem[rd_ptr] : 8'h00;

    // Stores accepted bytes while there is room in the buffer.
    always_ff @(posedge clk) begin
        if (take && room) begin
            mem[wr_cnt[AW-1:0]] <= rx_data;
        end
    end

    // Tracks frame fill, the published count and the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt    <= '0;
            rx_cnt    <= '0;
            rd_ptr    <= '0;
            rx_active <= 1'b0;
        end else if (take) begin
            if (rx_last) begin
                rx_cnt    <= room ? wr_cnt + 1'b1 : wr_cnt;
                wr_cnt    <= '0;
                rd_ptr    <= '0;
                rx_active <= 1'b0;
            end else begin
                if (room) begin
                    wr_cnt <= wr_cnt + 1'b1;
                end
                rx_active <= 1'b1;
            end
        end else if (rd_pop && rx_cnt != '0) begin
            rx_cnt <= rx_cnt - 1'b1;
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/netmbox_tx.sv
// Transmit side: collects a programmed number of bytes, then replays them on
// a valid/ready stream. Assumes one bus write per cycle. Lengths are clamped
// to FRAME_MAX; length writes are ignored while a frame is being sent.
module netmbox_tx #(
    parameter int FRAME_MAX = 64,
    localparam int CW = $clog2(FRAME_MAX + 1),
    localparam int AW = $clog2(FRAME_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_wr,
    input  logic [31:0]   len_val,
    input  logic          byte_wr,
    input  logic [7:0]    byte_val,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic [CW-1:0] tx_cnt,
    output logic          sending,
    output logic          sent_done
);
    localparam logic [CW-1:0] MAXC = CW'(FRAME_MAX);

    logic [7:0]    mem [FRAME_MAX];
    logic [CW-1:0] fill;
    logic [CW-1:0] len;
    logic [AW-1:0] ptr;
    logic          store;
    logic [CW-1:0] len_clamped;

    assign store       = byte_wr && (tx_cnt != '0);
    assign len_clamped = (len_val > 32'(FRAME_MAX)) ? MAXC : len_val[CW-1:0];
    assign tx_valid    = sending;
    assign tx_data     = mem[ptr];
    assign tx_last     = sending && ((CW'(ptr) + 1'b1) == len);
    assign sent_done   = tx_valid && tx_ready && tx_last;

    // Writes window bytes into the buffer while a length is pending.
    always_ff @(posedge clk) begin
        if (store) begin
            mem[fill[AW-1:0]] <= byte_val;
        end
    end

    // Sequences programming, fill, hand-off and replay of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt  <= '0;
            fill    <= '0;
            len     <= '0;
            ptr     <= '0;
            sending <= 1'b0;
        end else begin
            if (len_wr && !sending) begin
                tx_cnt <= len_clamped;
                fill   <= '0;
            end else if (store) begin
                if (fill + 1'b1 == tx_cnt) begin
                    tx_cnt  <= '0;
                    fill    <= '0;
                    len     <= tx_cnt;
                    ptr     <= '0;
                    sending <= 1'b1;
                end else begin
                    fill <= fill + 1'b1;
                end
            end
            if (tx_valid && tx_ready) begin
                if (tx_last) begin
                    sending <= 1'b0;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/netmbox_regs.sv
// Register decode: read multiplexer, access strobes and the interrupt
// control word. Accesses with bits 1:0 of the address nonzero are treated
// as unmapped. A hardware event set wins over a software clear in the same
// cycle.
module netmbox_regs #(
    parameter int          CW      = 7,
    parameter logic [63:0] ID_WORD = 64'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [5:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [CW-1:0] rx_cnt,
    input  logic [7:0]    rx_byte,
    input  logic [CW-1:0] tx_cnt,
    input  logic          busy,
    input  logic          set_tx,
    input  logic          set_rx,
    output logic          flag_tx,
    output logic          flag_rx,
    output logic          flag_test,
    output logic          rd_pop,
    output logic          len_wr,
    output logic          byte_wr,
    output logic          irq
);
    import netmbox_pkg::*;

    logic       aligned;
    logic [3:0] word;
    logic       rd;
    logic       wr;
    logic       wr_ctl;
    logic       rd_ctl;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[5:2];
    assign rd      = bus_req && !bus_we && aligned;
    assign wr      = bus_req && bus_we && aligned;
    assign wr_ctl  = wr && (word == W_INTCTL);
    assign rd_ctl  = rd && (word == W_INTCTL);
    assign rd_pop  = rd && (word == W_RXWIN);
    assign len_wr  = wr && (word == W_TXCNT);
    assign byte_wr = wr && (word == W_TXWIN);
    assign irq     = flag_tx || flag_rx || flag_test;

    // Selects the read value for the addressed word.
    always_comb begin
        bus_rdata = 32'h0;
        if (rd) begin
            case (word)
                W_ID_LO:  bus_rdata = ID_WORD[31:0];
                W_ID_HI:  bus_rdata = ID_WORD[63:32];
                W_BUSY:   bus_rdata = {31'h0, busy};
                W_RXCNT:  bus_rdata = 32'(rx_cnt);
                W_TXCNT:  bus_rdata = 32'(tx_cnt);
                W_INTCTL: bus_rdata = {flag_test, 29'h0, flag_rx, flag_tx};
                W_RXWIN:  bus_rdata = {24'h0, rx_byte};
                default:  bus_rdata = 32'h0;
            endcase
        end
    end

    // Latches events, applies write-one-to-clear and drives the test bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_tx   <= 1'b0;
            flag_rx   <= 1'b0;
            flag_test <= 1'b0;
        end else begin
            flag_tx <= set_tx || (flag_tx && !(wr_ctl && bus_wdata[0]));
            flag_rx <= set_rx || (flag_rx && !(wr_ctl && bus_wdata[1]));
            if (wr_ctl) begin
                flag_test <= bus_wdata[31];
            end else if (rd_ctl) begin
                flag_test <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/netmbox.sv
// Top: memory-mapped network byte mailbox. Joins the register decode with the
// receive and transmit buffers. FRAME_MAX sets buffer depth and the largest
// frame (up to 65536); ID_TEXT is an eight-character string literal.
module netmbox #(
    parameter int          FRAME_MAX = 64,
    parameter logic [63:0] ID_TEXT   = "MBOXNET1"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int CW = $clog2(FRAME_MAX + 1);
    localparam logic [63:0] ID_WORD = netmbox_pkg::pack_id(ID_TEXT);

    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_cnt;
    logic [7:0]    rx_byte;
    logic          rx_active;
    logic          frame_done;
    logic          sending;
    logic          sent_done;
    logic          flag_tx;
    logic          flag_rx;
    logic          flag_test;
    logic          rd_pop;
    logic          len_wr;
    logic          byte_wr;
    logic          busy;

    assign busy = rx_active || sending;

    netmbox_regs #(.CW(CW), .ID_WORD(ID_WORD)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_cnt(rx_cnt), .rx_byte(rx_byte), .tx_cnt(tx_cnt), .busy(busy),
        .set_tx(sent_done), .set_rx(frame_done),
        .flag_tx(flag_tx), .flag_rx(flag_rx), .flag_test(flag_test),
        .rd_pop(rd_pop), .len_wr(len_wr), .byte_wr(byte_wr), .irq(irq)
    );

    netmbox_rx #(.FRAME_MAX(FRAME_MAX)) i_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .hold(flag_rx), .rd_pop(rd_pop),
        .rx_ready(rx_ready), .rx_cnt(rx_cnt), .rx_byte(rx_byte),
        .rx_active(rx_active), .frame_done(frame_done)
    );

    netmbox_tx #(.FRAME_MAX(FRAME_MAX)) i_tx (
        .clk(clk), .rst_n(rst_n),
        .len_wr(len_wr), .len_val(bus_wdata),
        .byte_wr(byte_wr), .byte_val(bus_wdata[7:0]),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_cnt(tx_cnt), .sending(sending),
        .sent_done(sent_done)
    );

endmodule

// File: rtl/netmbox_checker.sv
// Checker: temporal properties of the mailbox, attached by bind to netmbox.
module netmbox_checker #(
    parameter int FRAME_MAX = 64,
    localparam int CW = $clog2(FRAME_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [5:0]    bus_addr,
    input logic          rx_ready,
    input logic [CW-1:0] rx_cnt,
    input logic          flag_rx,
    input logic          flag_test,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          busy
);
    // R5: an unacknowledged receive flag blocks the stream
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rx |-> !rx_ready);

    // R4: each window read with data pending lowers the count by one
    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == 6'h1C && rx_cnt != '0)
        |=> (rx_cnt == $past(rx_cnt) - 1'b1));

    // R6: the receive count never exceeds the buffer size
    p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(FRAME_MAX));

    // R7: a stalled outgoing byte is held unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R9: busy covers any frame on the outgoing stream
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    // R11: the test bit is gone after a read of interrupt control
    p_testclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == 6'h14) |=> !flag_test);

endmodule

bind netmbox netmbox_checker #(.FRAME_MAX(FRAME_MAX)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .rx_ready(rx_ready), .rx_cnt(rx_cnt),
    .flag_rx(flag_rx), .flag_test(flag_test), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .busy(busy)
);

// File: tb/test_netmbox.sv
// Bench for netmbox: a table walk of register accesses, then directed tests.
module test_netmbox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [7:0] coll_data [8];
    logic       coll_last [8];
    int         coll_n = 0;

    always #10 clk = ~clk;  // 50 MHz

    netmbox i_netmbox (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'h00, 32'h0, 32'h584F424D, 4'd1},  // R1 id low
        '{1'b0, 6'h04, 32'h0, 32'h3154454E, 4'd1},  // R1 id high
        '{1'b0, 6'h18, 32'h0, 32'h0, 4'd1},         // R1 info word
        '{1'b0, 6'h24, 32'h0, 32'h0, 4'd1},         // R1 unmapped
        '{1'b0, 6'h01, 32'h0, 32'h0, 4'd1},         // R1 misaligned
        '{1'b0, 6'h08, 32'h0, 32'h0, 4'd2},         // R2 busy
        '{1'b0, 6'h0C, 32'h0, 32'h0, 4'd2},         // R2 rx count
        '{1'b0, 6'h10, 32'h0, 32'h0, 4'd2},         // R2 tx count
        '{1'b0, 6'h14, 32'h0, 32'h0, 4'd2},         // R2 int control
        '{1'b0, 6'h1C, 32'h0, 32'h0, 4'd4},         // R4 empty window
        '{1'b1, 6'h14, 32'h80000000, 32'h0, 4'd11}, // R11 set test
        '{1'b0, 6'h14, 32'h0, 32'h80000000, 4'd11}, // R11 read shows it
        '{1'b0, 6'h14, 32'h0, 32'h0, 4'd11},        // R11 cleared by read
        '{1'b1, 6'h14, 32'h80000000, 32'h0, 4'd11},
        '{1'b1, 6'h14, 32'h00000000, 32'h0, 4'd11}, // R11 write 0 clears
        '{1'b0, 6'h14, 32'h0, 32'h0, 4'd11},
        '{1'b1, 6'h10, 32'h00000100, 32'h0, 4'd8},  // R8 oversize length
        '{1'b0, 6'h10, 32'h0, 32'h00000040, 4'd8},  // R8 clamped
        '{1'b1, 6'h10, 32'h0, 32'h0, 4'd8},
        '{1'b0, 6'h10, 32'h0, 32'h0, 4'd8}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_req = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] b, input logic last);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_last = last;
        @(posedge clk);
        #1 rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    // Records each outgoing handshake one half cycle ahead of its edge.
    always @(negedge clk) begin
        if (tx_valid && tx_ready && coll_n < 8) begin
            coll_data[coll_n] = tx_data;
            coll_last[coll_n] = tx_last;
            coll_n++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state of the stream and interrupt pins
        chk("R2 irq", {31'h0, irq}, 32'h0);
        chk("R2 rx_ready", {31'h0, rx_ready}, 32'h1);
        chk("R2 tx_valid", {31'h0, tx_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, d);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
            end
        end

        // R12 test bit drives irq; a second write of 1 keeps it set (R11)
        bus_write(6'h14, 32'h80000000);
        bus_write(6'h14, 32'h80000000);
        @(negedge clk);
        chk("R12 irq from test bit", {31'h0, irq}, 32'h1);
        bus_write(6'h14, 32'h0);
        @(negedge clk);
        chk("R12 irq low", {31'h0, irq}, 32'h0);

        // R3 and R9: five-byte frame, busy sampled mid-frame
        rx_byte(8'hA1, 1'b0);
        bus_read(6'h08, d);
        chk("R9 busy during rx", d, 32'h1);
        rx_byte(8'hA2, 1'b0);
        rx_byte(8'hA3, 1'b0);
        rx_byte(8'hA4, 1'b0);
        rx_byte(8'hA5, 1'b1);
        bus_read(6'h0C, d);
        chk("R3 rx count", d, 32'd5);
        bus_read(6'h14, d);
        chk("R3 rx flag", d, 32'h2);
        chk("R12 irq from rx", {31'h0, irq}, 32'h1);

        // R5 offered bytes are refused while the frame is pending
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77; rx_last = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 rx_ready while pending", {31'h0, rx_ready}, 32'h0);
        rx_valid = 1'b0; rx_last = 1'b0;
        bus_read(6'h0C, d);
        chk("R5 count unchanged", d, 32'd5);

        // R4 drain the frame byte by byte
        for (int i = 0; i < 5; i++) begin
            bus_read(6'h1C, d);
            chk($sformatf("R4 byte %0d", i), d, 32'(8'hA1 + i));
            bus_read(6'h0C, d);
            chk($sformatf("R4 count after %0d", i), d, 32'(4 - i));
        end
        bus_read(6'h1C, d);
        chk("R4 read past end", d, 32'h0);
        bus_read(6'h0C, d);
        chk("R4 count stays 0", d, 32'h0);
        @(negedge clk);
        chk("R5 gated by flag alone", {31'h0, rx_ready}, 32'h0);

        // R10 clearing the wrong bit leaves the rx flag, the right bit clears
        bus_write(6'h14, 32'h1);
        bus_read(6'h14, d);
        chk("R10 other bit kept", d, 32'h2);
        bus_write(6'h14, 32'h2);
        bus_read(6'h14, d);
        chk("R10 rx flag cleared", d, 32'h0);
        @(negedge clk);
        chk("R5 ready after ack", {31'h0, rx_ready}, 32'h1);
        chk("R12 irq after ack", {31'h0, irq}, 32'h0);

        // R7 transmit a three-byte frame with the sink stalled at first
        bus_write(6'h10, 32'd3);
        bus_read(6'h10, d);
        chk("R7 tx count programmed", d, 32'd3);
        bus_write(6'h20, 32'hFFFFFF11);
        bus_write(6'h20, 32'h00000022);
        bus_write(6'h20, 32'hABCDEF33);
        bus_read(6'h10, d);
        chk("R7 tx count cleared", d, 32'h0);
        @(negedge clk);
        chk("R7 first byte waiting", {23'h0, tx_valid, tx_data}, 32'h111);
        bus_read(6'h08, d);
        chk("R9 busy during tx", d, 32'h1);
        bus_write(6'h10, 32'd5);
        bus_read(6'h10, d);
        chk("R8 length ignored while sending", d, 32'h0);
        bus_write(6'h20, 32'h99);
        @(posedge clk);
        #1 tx_ready = 1'b1;
        repeat (8) @(posedge clk);
        chk("R7 bytes sent", 32'(coll_n), 32'd3);
        chk("R7 byte 0", {24'h0, coll_data[0]}, 32'h11);
        chk("R7 byte 1", {24'h0, coll_data[1]}, 32'h22);
        chk("R7 byte 2", {24'h0, coll_data[2]}, 32'h33);
        chk("R7 last marks", {29'h0, coll_last[0], coll_last[1], coll_last[2]}, 32'h1);
        bus_read(6'h14, d);
        chk("R7 tx done flag", d, 32'h1);
        bus_write(6'h14, 32'h1);
        bus_read(6'h08, d);
        chk("R9 idle after tx", d, 32'h0);

        // R8 window writes with no length pending give no stream output
        bus_write(6'h20, 32'h55);
        repeat (4) @(posedge clk);
        chk("R8 dropped write", 32'(coll_n), 32'd3);
        bus_read(6'h14, d);
        chk("R8 no tx flag", d, 32'h0);

        // R6 a 70-byte frame keeps only the first 64 bytes
        for (int i = 0; i < 70; i++) begin
            rx_byte(8'(i), i == 69);
        end
        bus_read(6'h0C, d);
        chk("R6 count capped", d, 32'd64);
        bus_read(6'h1C, d);
        chk("R6 first byte", d, 32'h0);
        for (int i = 1; i < 63; i++) begin
            bus_read(6'h1C, d);
        end
        bus_read(6'h1C, d);
        chk("R6 last kept byte", d, 32'd63);
        bus_read(6'h0C, d);
        chk("R6 drained", d, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule